// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

This block collects up to 64 device interrupt request lines into one shared request vector and routes them to four processors. Every processor owns a 64-bit enable mask; the lines a processor sees as pending are its mask ANDed with the shared request vector. Each processor receives one level interrupt that stays high while any of its pending bits is set.

Software reaches the masks, the pending vectors and the shared request vector through a single-beat 64-bit register port. Registers are addressed either by a register number (the byte offset shifted right by six) or through an alternate per-processor window. In that window, a flag bit picks the mask or the pending view and offset bits [9:4] pick the processor. Devices drive per-line set and clear pulses.

Whenever the routed state of a line changes for a processor, the block emits a one-cycle strobe: a post strobe when the line becomes pending, a clear strobe when it stops being pending. A change can come from a mask write, from a device event, or from both in the same cycle. Illegal or unsupported accesses are refused and recorded in a sticky error flag.

Top module: `irq_router`

## Requirements
- R1: A full-size write to byte offset 0x40*c (c = 0..3) loads processor c's 64-bit mask. A read of the same offset returns it in the cycle after the request, with `rsp_valid_o` high.
- R2: A read of offset 0x100+0x40*c returns processor c's pending vector, equal to mask c AND the request vector. A read of offset 0x200 returns the request vector.
- R3: A pulse on `dev_set_i[n]` sets request bit n. In the next cycle every processor whose mask has bit n enabled shows a post strobe at `post_o[64*c+n]`. When set and clear hit the same line in the same cycle, set wins.
- R4: A pulse on `dev_clr_i[n]` clears request bit n. In the next cycle every processor that had bit n pending shows a clear strobe at `clear_o[64*c+n]`.
- R5: A mask write raises a post strobe for each bit that becomes pending and a clear strobe for each bit that stops being pending. Bits whose pending state does not change get no strobe.
- R6: A clear pulse on a line whose request bit is already zero changes no state and produces no strobe.
- R7: `irq_o[c]` is a registered OR of processor c's pending vector. It changes in the same cycle as the pending vector it reflects.
- R8: Offset bit 15 selects the alternate mask window and bit 14 selects the alternate pending window; bit 15 wins when both are set. Offset bits [9:4] give the processor. An index of 4 or more reads zero, and a mask write to such an index is an error.
- R9: Only `req_size_i` = 3 (eight bytes) is legal. Any other size sets the error flag, changes no register and reads zero.
- R10: Writes to a pending register, to the request-vector register, to the alternate pending window or to an unused register number are refused. They set the error flag and leave every register unchanged.
- R11: The error flag stays set until reset. Reads of unused register numbers return zero.
- R12: A mask write and a device event in the same cycle both take effect. Pending and strobes are computed from the new mask and the new request vector together.
- R13: After reset all masks, pending vectors, the request vector, `irq_o` and `err_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Log2 of access size in bytes; only 3 is legal |
| req_addr_i | input | 16 | Byte offset inside the block |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata_o | output | 64 | Read data |
| dev_set_i | input | 64 | Per-line request set pulses |
| dev_clr_i | input | 64 | Per-line request clear pulses |
| irq_o | output | 4 | Per-processor level interrupt |
| post_o | output | 256 | Per-processor, per-line post strobes (bit 64*c+n) |
| clear_o | output | 256 | Per-processor, per-line clear strobes (bit 64*c+n) |
| err_o | output | 1 | Sticky access error flag |

## Verification
A mask write arriving in the same cycle as a device set pulse is the collision that matters. The pending vector must be rebuilt from both new values at once, not from one new value and one stale one. The bench drives a mask write to processor 3 enabling line 50 in the same cycle that line 50 is raised. It then expects a post strobe for processor 3 (new mask, new request) and one for processor 1 (old mask, new request). It also checks that every processor's interrupt level and the pending read-back agree with both updates.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;

  // Width of the processor index field carried by the decoder
  localparam int CPU_IDX_W = 6;

  // Only full-width (eight byte) accesses are legal
  localparam logic [1:0] SIZE_FULL = 2'd3;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_MASK = 2'd1,
    SRC_PEND = 2'd2,
    SRC_RAW  = 2'd3
  } rd_src_e;

  typedef struct packed {
    logic                 mask_we;
    logic                 err;
    rd_src_e              src;
    logic [CPU_IDX_W-1:0] cpu;
  } dec_t;

endpackage

// File: rtl/irq_rt_decode.sv
module irq_rt_decode
  import irq_rt_pkg::*;
#(
  parameter int NCPU         = 4,
  parameter int AW           = 16,
  parameter int ALT_MASK_BIT = 15,
  parameter int ALT_PEND_BIT = 14
) (
  input  logic          valid_i,
  input  logic          write_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] addr_i,
  output dec_t          dec_o
);

  localparam int RW = AW - 6;

  logic [RW-1:0]        regnum;
  logic [CPU_IDX_W-1:0] alt_cpu;
  logic                 alt_ok;

  assign regnum  = addr_i[AW-1:6];
  assign alt_cpu = addr_i[9:4];
  assign alt_ok  = int'(alt_cpu) < NCPU;

  always_comb begin
    dec_o = '0;
    if (valid_i) begin
      if (size_i != SIZE_FULL) begin
        dec_o.err = 1'b1;
      end else if (addr_i[ALT_MASK_BIT]) begin
        // alternate mask window has priority over the pending window
        if (!alt_ok) begin
          dec_o.err = write_i;
        end else if (write_i) begin
          dec_o.mask_we = 1'b1;
          dec_o.cpu     = alt_cpu;
        end else begin
          dec_o.src = SRC_MASK;
          dec_o.cpu = alt_cpu;
        end
      end else if (addr_i[ALT_PEND_BIT]) begin
        if (write_i) begin
          dec_o.err = 1'b1;
        end else if (alt_ok) begin
          dec_o.src = SRC_PEND;
          dec_o.cpu = alt_cpu;
        end
      end else if (int'(regnum) < NCPU) begin
        if (write_i) begin
          dec_o.mask_we = 1'b1;
        end else begin
          dec_o.src = SRC_MASK;
        end
        dec_o.cpu = CPU_IDX_W'(regnum);
      end else if (int'(regnum) < 2 * NCPU) begin
        if (write_i) begin
          dec_o.err = 1'b1;
        end else begin
          dec_o.src = SRC_PEND;
          dec_o.cpu = CPU_IDX_W'(int'(regnum) - NCPU);
        end
      end else if (int'(regnum) == 2 * NCPU) begin
        if (write_i) begin
          dec_o.err = 1'b1;
        end else begin
          dec_o.src = SRC_RAW;
        end
      end else begin
        // unused register numbers: reads give zero, writes are refused
        dec_o.err = write_i;
      end
    end
  end

endmodule

// File: rtl/irq_rt_raw.sv
module irq_rt_raw #(
  parameter int NLINE = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NLINE-1:0] set_i,
  input  logic [NLINE-1:0] clr_i,
  output logic [NLINE-1:0] raw_o,
  output logic [NLINE-1:0] raw_next_o
);

  logic [NLINE-1:0] raw_q;
  logic             raw_en;

  // set has priority over clear on the same line
  always_comb begin
    raw_next_o = (raw_q & ~clr_i) | set_i;
    raw_en     = |(set_i | clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
    end else if (raw_en) begin
      raw_q <= raw_next_o;
    end
  end

  assign raw_o = raw_q;

endmodule

// File: rtl/irq_rt_cpu_slice.sv
module irq_rt_cpu_slice #(
  parameter int NLINE = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  logic [NLINE-1:0] wdata_i,
  input  logic [NLINE-1:0] raw_next_i,
  output logic [NLINE-1:0] mask_o,
  output logic [NLINE-1:0] pend_o,
  output logic [NLINE-1:0] post_o,
  output logic [NLINE-1:0] clr_o,
  output logic             irq_o
);

  logic [NLINE-1:0] mask_q, pend_q, post_q, clr_q;
  logic             irq_q;
  logic [NLINE-1:0] mask_next, pend_next, post_next, clr_next;
  logic             irq_next;

  always_comb begin
    mask_next = mask_we_i ? wdata_i : mask_q;
    pend_next = mask_next & raw_next_i;
    post_next = pend_next & ~pend_q;
    clr_next  = pend_q & ~pend_next;
    irq_next  = |pend_next;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= mask_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      post_q <= '0;
      clr_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_next;
      post_q <= post_next;
      clr_q  <= clr_next;
      irq_q  <= irq_next;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign post_o = post_q;
  assign clr_o  = clr_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_rt_pkg::*;
#(
  parameter int NCPU         = 4,
  parameter int NLINE        = 64,
  parameter int AW           = 16,
  parameter int ALT_MASK_BIT = 15,
  parameter int ALT_PEND_BIT = 14
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic [1:0]            req_size_i,
  input  logic [AW-1:0]         req_addr_i,
  input  logic [NLINE-1:0]      req_wdata_i,
  output logic                  rsp_valid_o,
  output logic [NLINE-1:0]      rsp_rdata_o,
  input  logic [NLINE-1:0]      dev_set_i,
  input  logic [NLINE-1:0]      dev_clr_i,
  output logic [NCPU-1:0]       irq_o,
  output logic [NCPU*NLINE-1:0] post_o,
  output logic [NCPU*NLINE-1:0] clear_o,
  output logic                  err_o
);

  localparam int SW = (NCPU > 1) ? $clog2(NCPU) : 1;

  dec_t                        dec;
  logic [NLINE-1:0]            raw_q, raw_next;
  logic [NCPU-1:0][NLINE-1:0]  mask_all, pend_all, post_all, clr_all;
  logic [NLINE-1:0]            rd_mux;
  logic                        rsp_valid_q, rsp_valid_next, rd_en;
  logic [NLINE-1:0]            rdata_q;
  logic                        err_q, err_next;

  irq_rt_decode #(
    .NCPU(NCPU), .AW(AW), .ALT_MASK_BIT(ALT_MASK_BIT), .ALT_PEND_BIT(ALT_PEND_BIT)
  ) u_dec (
    .valid_i(req_valid_i),
    .write_i(req_write_i),
    .size_i (req_size_i),
    .addr_i (req_addr_i),
    .dec_o  (dec)
  );

  irq_rt_raw #(.NLINE(NLINE)) u_raw (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (dev_set_i),
    .clr_i     (dev_clr_i),
    .raw_o     (raw_q),
    .raw_next_o(raw_next)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic we_c;
    assign we_c = dec.mask_we && (dec.cpu == CPU_IDX_W'(c));

    irq_rt_cpu_slice #(.NLINE(NLINE)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mask_we_i (we_c),
      .wdata_i   (req_wdata_i),
      .raw_next_i(raw_next),
      .mask_o    (mask_all[c]),
      .pend_o    (pend_all[c]),
      .post_o    (post_all[c]),
      .clr_o     (clr_all[c]),
      .irq_o     (irq_o[c])
    );
  end

  always_comb begin
    unique case (dec.src)
      SRC_MASK: rd_mux = mask_all[dec.cpu[SW-1:0]];
      SRC_PEND: rd_mux = pend_all[dec.cpu[SW-1:0]];
      SRC_RAW:  rd_mux = raw_q;
      default:  rd_mux = '0;
    endcase
    rd_en          = req_valid_i && !req_write_i;
    rsp_valid_next = rd_en;
    err_next       = err_q | dec.err;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_valid_next;
      err_q       <= err_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_mux;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;
  assign post_o      = post_all;
  assign clear_o     = clr_all;
  assign err_o       = err_q;

endmodule

// File: rtl/irq_rt_chk.sv
module irq_rt_chk #(
  parameter int NCPU  = 4,
  parameter int NLINE = 64
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NCPU-1:0][NLINE-1:0] mask_i,
  input logic [NCPU-1:0][NLINE-1:0] pend_i,
  input logic [NLINE-1:0]          raw_i,
  input logic [NCPU*NLINE-1:0]     post_i,
  input logic [NCPU*NLINE-1:0]     clr_i,
  input logic [NCPU-1:0]           irq_i,
  input logic                      err_i,
  input logic [NLINE-1:0]          dev_set_i,
  input logic [NLINE-1:0]          dev_clr_i
);

  for (genvar c = 0; c < NCPU; c++) begin : g_c
    // pending of each processor follows mask AND request
    p_pend_and_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_i[c] == (mask_i[c] & raw_i));

    p_irq_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[c] == (|pend_i[c]));

    p_post_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      post_i[c*NLINE +: NLINE] == (pend_i[c] & ~$past(pend_i[c])));

    p_clear_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[c*NLINE +: NLINE] == ($past(pend_i[c]) & ~pend_i[c]));
  end

  p_set_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_set_i != '0) |=> ((raw_i & $past(dev_set_i)) == $past(dev_set_i)));

  p_spurious_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dev_clr_i != '0) && ((dev_clr_i & raw_i) == '0) && (dev_set_i == '0))
      |=> (raw_i == $past(raw_i)));

  p_err_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i);

endmodule

bind irq_router irq_rt_chk #(.NCPU(NCPU), .NLINE(NLINE)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mask_i   (mask_all),
  .pend_i   (pend_all),
  .raw_i    (raw_q),
  .post_i   (post_o),
  .clr_i    (clear_o),
  .irq_i    (irq_o),
  .err_i    (err_o),
  .dev_set_i(dev_set_i),
  .dev_clr_i(dev_clr_i)
);

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;

  localparam int NCPU  = 4;
  localparam int NLINE = 64;
  localparam int AW    = 16;
  localparam int WV    = NCPU * NLINE;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid, req_write;
  logic [1:0]       req_size;
  logic [AW-1:0]    req_addr;
  logic [NLINE-1:0] req_wdata;
  logic             rsp_valid;
  logic [NLINE-1:0] rsp_rdata;
  logic [NLINE-1:0] dev_set, dev_clr;
  logic [NCPU-1:0]  irq;
  logic [WV-1:0]    post, clr;
  logic             err;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irq_router #(.NCPU(NCPU), .NLINE(NLINE), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_size_i(req_size),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .dev_set_i(dev_set), .dev_clr_i(dev_clr),
    .irq_o(irq), .post_o(post), .clear_o(clr), .err_o(err)
  );

  function automatic logic [WV-1:0] at(int c, int line);
    return WV'(1) << (c * NLINE + line);
  endfunction

  function automatic logic [AW-1:0] a_mask(int c);
    return AW'(c * 64);
  endfunction

  function automatic logic [AW-1:0] a_pend(int c);
    return AW'(256 + c * 64);
  endfunction

  localparam logic [AW-1:0] A_RAW = 16'h0200;

  task automatic chk(string tag, logic [WV-1:0] act, logic [WV-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a,
                     input logic [NLINE-1:0] wd, output logic [NLINE-1:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd = rsp_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NLINE-1:0] d);
    logic [NLINE-1:0] unused;
    bus(1'b1, 2'd3, a, d, unused);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [NLINE-1:0] d);
    bus(1'b0, 2'd3, a, '0, d);
  endtask

  task automatic dev(input logic [NLINE-1:0] s, input logic [NLINE-1:0] c);
    @(negedge clk);
    dev_set = s; dev_clr = c;
    @(negedge clk);
    dev_set = '0; dev_clr = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd3; req_addr = '0; req_wdata = '0;
    dev_set = '0; dev_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [NLINE-1:0] d;
    chk("R13 irq after reset", WV'(irq), '0);
    chk("R13 err after reset", WV'(err), '0);
    rd(a_mask(0), d);
    chk("R13 mask0 after reset", WV'(d), '0);
    chk("R1 rsp_valid on read", WV'(rsp_valid), WV'(1));
    rd(A_RAW, d);
    chk("R13 raw after reset", WV'(d), '0);
  endtask

  task automatic t_mask_rw();
    logic [NLINE-1:0] d;
    wr(a_mask(0), 64'h0000_0000_0000_00F0);
    wr(a_mask(1), 64'hA5A5_A5A5_A5A5_A5A5);
    rd(a_mask(1), d);
    chk("R1 mask1 readback", WV'(d), WV'(64'hA5A5_A5A5_A5A5_A5A5));
    rd(a_mask(0), d);
    chk("R1 mask0 readback", WV'(d), WV'(64'hF0));
    chk("R5 no strobe with empty request", post | clr, '0);
  endtask

  task automatic t_dev_set();
    logic [NLINE-1:0] d;
    dev(NLINE'(1) << 5, '0);
    chk("R3 post on line 5", post, at(0, 5) | at(1, 5));
    chk("R3 no clear on set", clr, '0);
    chk("R7 irq after set", WV'(irq), WV'(4'b0011));
    @(negedge clk);
    chk("R3 strobe lasts one cycle", post, '0);
    dev(NLINE'(1) << 4, NLINE'(1) << 4);
    chk("R3 set wins over clear", post, at(0, 4));
    rd(A_RAW, d);
    chk("R3 raw after sets", WV'(d), WV'(64'h30));
  endtask

  task automatic t_pend_read();
    logic [NLINE-1:0] d;
    rd(a_pend(0), d);
    chk("R2 pend0", WV'(d), WV'(64'h30));
    rd(a_pend(1), d);
    chk("R2 pend1", WV'(d), WV'(64'h20));
    rd(a_pend(2), d);
    chk("R2 pend2", WV'(d), '0);
  endtask

  task automatic t_mask_change();
    wr(a_mask(0), 64'h0F);
    chk("R5 clear strobes on unmask", clr, at(0, 4) | at(0, 5));
    chk("R5 no post on unmask", post, '0);
    chk("R7 irq0 drops", WV'(irq), WV'(4'b0010));
    wr(a_mask(0), 64'h30);
    chk("R5 post strobes on remask", post, at(0, 4) | at(0, 5));
    chk("R7 irq0 rises", WV'(irq), WV'(4'b0011));
    wr(a_mask(0), 64'h30);
    chk("R5 no strobe on same mask", post | clr, '0);
  endtask

  task automatic t_dev_clr();
    logic [NLINE-1:0] d;
    dev('0, NLINE'(1) << 5);
    chk("R4 clear strobes line 5", clr, at(0, 5) | at(1, 5));
    chk("R7 irq after clear", WV'(irq), WV'(4'b0001));
    rd(A_RAW, d);
    chk("R4 raw after clear", WV'(d), WV'(64'h10));
  endtask

  task automatic t_spurious();
    logic [NLINE-1:0] d;
    dev('0, NLINE'(1) << 40);
    chk("R6 no strobe on spurious clear", post | clr, '0);
    chk("R6 irq unchanged", WV'(irq), WV'(4'b0001));
    rd(A_RAW, d);
    chk("R6 raw unchanged", WV'(d), WV'(64'h10));
    rd(a_pend(0), d);
    chk("R6 pend0 unchanged", WV'(d), WV'(64'h10));
  endtask

  task automatic t_alt();
    logic [NLINE-1:0] d;
    wr(16'h8020, 64'hFFFF);
    chk("R8 alt mask write posts", post, at(2, 4));
    chk("R8 irq2 set", WV'(irq), WV'(4'b0101));
    rd(a_mask(2), d);
    chk("R8 alt write seen at normal offset", WV'(d), WV'(64'hFFFF));
    rd(16'h4020, d);
    chk("R8 alt pend read", WV'(d), WV'(64'h10));
    rd(16'hC020, d);
    chk("R8 mask flag has priority", WV'(d), WV'(64'hFFFF));
    rd(16'h8090, d);
    chk("R8 alt index out of range reads zero", WV'(d), '0);
    chk("R8 no error on legal alt reads", WV'(err), '0);
  endtask

  task automatic t_simul();
    logic [NLINE-1:0] d;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd3;
    req_addr = a_mask(3); req_wdata = NLINE'(1) << 50;
    dev_set = NLINE'(1) << 50;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; dev_set = '0;
    chk("R12 posts from new mask and new request", post, at(1, 50) | at(3, 50));
    chk("R12 irq all", WV'(irq), WV'(4'b1111));
    rd(a_pend(3), d);
    chk("R12 pend3", WV'(d), WV'(NLINE'(1) << 50));
  endtask

  task automatic t_err_size();
    logic [NLINE-1:0] d;
    bus(1'b1, 2'd2, a_mask(0), 64'hDEAD, d);
    chk("R9 error on short write", WV'(err), WV'(1));
    rd(a_mask(0), d);
    chk("R9 mask unchanged", WV'(d), WV'(64'h30));
    bus(1'b0, 2'd1, a_mask(0), '0, d);
    chk("R9 short read returns zero", WV'(d), '0);
  endtask

  task automatic t_err_ro();
    logic [NLINE-1:0] d;
    do_reset();
    chk("R13 err cleared by reset", WV'(err), '0);
    dev(NLINE'(1) << 3, '0);
    wr(A_RAW, '0);
    chk("R10 raw write refused", WV'(err), WV'(1));
    rd(A_RAW, d);
    chk("R10 raw unchanged", WV'(d), WV'(64'h8));
    do_reset();
    wr(a_pend(0), 64'hFF);
    chk("R10 pend write refused", WV'(err), WV'(1));
    rd(a_mask(0), d);
    chk("R10 mask0 untouched by pend write", WV'(d), '0);
    do_reset();
    wr(16'h4000, 64'hFF);
    chk("R10 alt pend write refused", WV'(err), WV'(1));
    rd(a_mask(0), d);
    chk("R10 mask0 untouched by alt pend write", WV'(d), '0);
    do_reset();
    wr(16'h8090, 64'hFF);
    chk("R8 alt mask write out of range refused", WV'(err), WV'(1));
    do_reset();
    wr(16'h0240, 64'hFF);
    chk("R10 reserved write refused", WV'(err), WV'(1));
    rd(16'h0280, d);
    chk("R11 reserved read zero", WV'(d), '0);
    chk("R11 error stays set", WV'(err), WV'(1));
  endtask

  initial begin
    do_reset();
    t_reset();
    t_mask_rw();
    t_dev_set();
    t_pend_read();
    t_mask_change();
    t_dev_clr();
    t_spurious();
    t_alt();
    t_simul();
    t_err_size();
    t_err_ro();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule